// File: doc/BRIEF.md
# Processor Control and Interrupt Register Bank

This block keeps the small set of control registers a processor core consults on every instruction boundary: the live status word, two saved copies of status (one for exception return, one for debug return), the interrupt enable mask, a pending view, and a fixed identifier. The core reaches them through read-control and write-control operations. Each operation names one of 32 slots by a 5-bit index, which the decoder upstream takes from instruction bits 10..6.

Pending is not a stored register. It is formed from the live interrupt lines masked by the enable register. The block also drives the interrupt request to the core. Privilege is checked against a mode input, and a return-from-exception strobe restores the status word from its saved copy.

Top module: `ctl_regfile`

## Requirements
- R1: After reset, the status, saved-exception-status, saved-debug-status and enable slots all read as zero, and `irq_req` is low.
- R2: The slot index map is: 0 status, 1 saved exception status, 2 saved debug status, 3 enable, 4 pending, 5 identifier. A supervisor write to slots 0..3 takes effect at the clock edge of the write, and a later read of the same slot returns the written value.
- R3: A read of slot 4 returns `irq_lines` AND enable from the same cycle, zero-extended to the data width.
- R4: A write to slot 4 changes no register.
- R5: While `usr_mode` is high, any read or write strobe raises `priv_fault` in the same cycle. Such a write changes no register. Such a read keeps `rd_wen` low and returns zero data.
- R6: When a supervisor read names destination register 0 (`rd_dst` = 0), `rd_wen` stays low, so the result is discarded.
- R7: When `eret` is high, the status register loads the saved exception status at that edge. `eret` has priority over a same-cycle write to slot 0.
- R8: `irq_req` is high exactly when status bit 0 (the interrupt-enable bit) is set and `irq_lines` AND enable is nonzero. After a write to status or enable, the request reflects the new value in the very next cycle.
- R9: Slot 5 always reads the `CPU_ID` parameter and ignores writes. Slots 6..31 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | NIRQ | Live hardware interrupt lines |
| rd_req | input | 1 | Read-control strobe |
| wr_req | input | 1 | Write-control strobe |
| ctl_idx | input | IDX_W | Control slot index |
| rd_dst | input | REG_W | Destination general register of a read |
| wr_data | input | DATA_W | Write data |
| usr_mode | input | 1 | High when the issuing instruction runs in user mode |
| eret | input | 1 | Return-from-exception strobe |
| rd_data | output | DATA_W | Read result (zero when no permitted read) |
| rd_wen | output | 1 | Write enable for the destination register |
| priv_fault | output | 1 | Supervisor-only operation issued from user mode |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The pending read is exercised with several line patterns against one enable mask. This separates a true AND from a pass-through of either operand, and from a stale stored copy. The interrupt request is observed on the cycle of a write to status or enable and on the cycle after it, which shows that the request follows the updated register with no added delay. Writes to the pending slot, user-mode writes and writes to unused slots are each followed by supervisor reads that would reveal any stray update. An exception return issued together with a status write shows which of the two wins.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
   localparam int unsigned SLOT_STATUS  = 0;
   localparam int unsigned SLOT_ESAVE   = 1;
   localparam int unsigned SLOT_BSAVE   = 2;
   localparam int unsigned SLOT_ENABLE  = 3;
   localparam int unsigned SLOT_PENDING = 4;
   localparam int unsigned SLOT_IDENT   = 5;
   localparam int unsigned SLOT_COUNT   = 6;
   localparam int unsigned PIE_BIT      = 0;

   typedef struct packed {
      logic status;
      logic esave;
      logic bsave;
      logic enable;
      logic pending;
      logic ident;
   } slot_sel_t;
endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
   import ctlreg_pkg::*;
#(
   parameter int unsigned IDX_W = 5
) (
   input  logic [IDX_W-1:0] idx,
   output slot_sel_t        sel
);
   generate
      if (IDX_W < $clog2(SLOT_COUNT)) begin : g_bad_idx
         $error("ctlreg_decode: IDX_W too narrow for the slot map");
      end
   endgenerate

   always_comb begin
      sel         = '0;
      sel.status  = (idx == IDX_W'(SLOT_STATUS));
      sel.esave   = (idx == IDX_W'(SLOT_ESAVE));
      sel.bsave   = (idx == IDX_W'(SLOT_BSAVE));
      sel.enable  = (idx == IDX_W'(SLOT_ENABLE));
      sel.pending = (idx == IDX_W'(SLOT_PENDING));
      sel.ident   = (idx == IDX_W'(SLOT_IDENT));
   end
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
   import ctlreg_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NIRQ   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  slot_sel_t         wsel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              eret,
   output logic [DATA_W-1:0] status_q,
   output logic [DATA_W-1:0] esave_q,
   output logic [DATA_W-1:0] bsave_q,
   output logic [NIRQ-1:0]   enable_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         esave_q  <= '0;
         bsave_q  <= '0;
         enable_q <= '0;
      end else begin
         if (eret)
            status_q <= esave_q;
         else if (wr_ok && wsel.status)
            status_q <= wdata;
         if (wr_ok && wsel.esave)
            esave_q <= wdata;
         if (wr_ok && wsel.bsave)
            bsave_q <= wdata;
         if (wr_ok && wsel.enable)
            enable_q <= wdata[NIRQ-1:0];
      end
   end
endmodule

// File: rtl/ctlreg_irq.sv
module ctlreg_irq #(
   parameter int unsigned NIRQ    = 32,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NIRQ-1:0] lines,
   input  logic [NIRQ-1:0] enable,
   input  logic            pie,
   output logic [NIRQ-1:0] pending,
   output logic            irq_req
);
   logic want;

   assign pending = lines & enable;
   assign want    = pie & (|pending);

   generate
      if (IRQ_REG) begin : g_flop
         logic req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= want;
         end
         assign irq_req = req_q;
      end else begin : g_comb
         assign irq_req = want;
      end
   endgenerate
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
   import ctlreg_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NIRQ    = 32,
   parameter int unsigned IDX_W   = 5,
   parameter int unsigned REG_W   = 5,
   parameter logic [31:0] CPU_ID  = 32'h0000_0000,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NIRQ-1:0]   irq_lines,
   input  logic              rd_req,
   input  logic              wr_req,
   input  logic [IDX_W-1:0]  ctl_idx,
   input  logic [REG_W-1:0]  rd_dst,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              usr_mode,
   input  logic              eret,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_wen,
   output logic              priv_fault,
   output logic              irq_req
);
   localparam int unsigned PAD_W = DATA_W - NIRQ;

   generate
      if (NIRQ > DATA_W || NIRQ == 0) begin : g_bad_nirq
         $error("ctl_regfile: NIRQ must be 1..DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("ctl_regfile: DATA_W must hold the status flags");
      end
   endgenerate

   slot_sel_t         sel;
   logic              rd_ok, wr_ok;
   logic [DATA_W-1:0] status_q, esave_q, bsave_q;
   logic [NIRQ-1:0]   enable_q, pending;
   logic [DATA_W-1:0] enable_x, pending_x, rd_val;

   assign rd_ok = rd_req & ~usr_mode;
   assign wr_ok = wr_req & ~usr_mode;

   ctlreg_decode #(.IDX_W(IDX_W)) u_dec (
      .idx (ctl_idx),
      .sel (sel)
   );

   ctlreg_bank #(.DATA_W(DATA_W), .NIRQ(NIRQ)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ok    (wr_ok),
      .wsel     (sel),
      .wdata    (wr_data),
      .eret     (eret),
      .status_q (status_q),
      .esave_q  (esave_q),
      .bsave_q  (bsave_q),
      .enable_q (enable_q)
   );

   ctlreg_irq #(.NIRQ(NIRQ), .IRQ_REG(IRQ_REG)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .lines   (irq_lines),
      .enable  (enable_q),
      .pie     (status_q[PIE_BIT]),
      .pending (pending),
      .irq_req (irq_req)
   );

   generate
      if (PAD_W == 0) begin : g_full
         assign enable_x  = enable_q;
         assign pending_x = pending;
      end else begin : g_pad
         assign enable_x  = {{PAD_W{1'b0}}, enable_q};
         assign pending_x = {{PAD_W{1'b0}}, pending};
      end
   endgenerate

   always_comb begin
      rd_val = '0;
      if (sel.status)  rd_val = status_q;
      if (sel.esave)   rd_val = esave_q;
      if (sel.bsave)   rd_val = bsave_q;
      if (sel.enable)  rd_val = enable_x;
      if (sel.pending) rd_val = pending_x;
      if (sel.ident)   rd_val = DATA_W'(CPU_ID);
   end

   assign rd_data    = rd_ok ? rd_val : '0;
   assign rd_wen     = rd_ok & (rd_dst != '0);
   assign priv_fault = (rd_req | wr_req) & usr_mode;
endmodule

// File: rtl/ctl_regfile_chk.sv
module ctl_regfile_chk #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NIRQ    = 32,
   parameter int unsigned IDX_W   = 5,
   parameter int unsigned REG_W   = 5,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NIRQ-1:0]   irq_lines,
   input logic              rd_req,
   input logic              wr_req,
   input logic [IDX_W-1:0]  ctl_idx,
   input logic [REG_W-1:0]  rd_dst,
   input logic              usr_mode,
   input logic              eret,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_wen,
   input logic              priv_fault,
   input logic              irq_req,
   input logic [DATA_W-1:0] st,
   input logic [DATA_W-1:0] est,
   input logic [NIRQ-1:0]   en
);
   p_pend_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !usr_mode && ctl_idx == IDX_W'(4)) |-> rd_data[NIRQ-1:0] == (irq_lines & en));

   p_pend_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !eret && ctl_idx == IDX_W'(4)) |=> ($stable(st) && $stable(est) && $stable(en)));

   p_fault_no_wen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      priv_fault |-> !rd_wen);

   p_user_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && usr_mode && !eret) |=> ($stable(st) && $stable(est) && $stable(en)));

   p_dst_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_dst == '0) |-> !rd_wen);

   p_eret_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eret |=> (st == $past(est)));

   p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && ctl_idx > IDX_W'(5)) |-> rd_data == '0);

   generate
      if (IRQ_REG) begin : g_reg
         p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!st[0] || en == '0) |=> !irq_req);
      end else begin : g_comb
         p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!st[0] || en == '0) |-> !irq_req);
      end
   endgenerate
endmodule

bind ctl_regfile ctl_regfile_chk #(
   .DATA_W(DATA_W), .NIRQ(NIRQ), .IDX_W(IDX_W), .REG_W(REG_W), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .rd_req(rd_req), .wr_req(wr_req),
   .ctl_idx(ctl_idx), .rd_dst(rd_dst), .usr_mode(usr_mode), .eret(eret),
   .rd_data(rd_data), .rd_wen(rd_wen), .priv_fault(priv_fault), .irq_req(irq_req),
   .st(status_q), .est(esave_q), .en(enable_q)
);

// File: tb/sim_ctl_regfile.sv
`timescale 1ns/1ps
module sim_ctl_regfile;
   localparam logic [31:0] ID = 32'h5EED_0042;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_lines = '0;
   logic        rd_req = 1'b0, wr_req = 1'b0, usr_mode = 1'b0, eret = 1'b0;
   logic [4:0]  ctl_idx = '0, rd_dst = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        rd_wen, priv_fault, irq_req;

   always #4 clk = ~clk;

   ctl_regfile #(.CPU_ID(ID)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .rd_req(rd_req), .wr_req(wr_req),
      .ctl_idx(ctl_idx), .rd_dst(rd_dst), .wr_data(wr_data), .usr_mode(usr_mode),
      .eret(eret), .rd_data(rd_data), .rd_wen(rd_wen), .priv_fault(priv_fault),
      .irq_req(irq_req)
   );

   typedef struct packed {
      logic [31:0] data;
      logic        cd;
      logic        wen;
      logic        flt;
      logic        irq;
   } exp_t;

   exp_t  eq[$];
   string tq[$];
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   // reference state built from the requirements
   logic [31:0] m_st = '0, m_est = '0, m_bst = '0, m_en = '0;

   function automatic logic [31:0] m_read(input logic [4:0] idx, input logic [31:0] ln);
      case (idx)
         5'd0: return m_st;
         5'd1: return m_est;
         5'd2: return m_bst;
         5'd3: return m_en;
         5'd4: return ln & m_en;
         5'd5: return ID;
         default: return 32'h0;
      endcase
   endfunction

   // monitor: pops one expected item per checked cycle
   always @(negedge clk) begin
      if (eq.size() != 0) begin
         exp_t  e;
         string t;
         e = eq.pop_front();
         t = tq.pop_front();
         n_chk++;
         if ((e.cd && rd_data !== e.data) || rd_wen !== e.wen ||
             priv_fault !== e.flt || irq_req !== e.irq) begin
            n_fail++;
            $display("FAIL %s actual data=%h wen=%b flt=%b irq=%b expected data=%h wen=%b flt=%b irq=%b",
                     t, rd_data, rd_wen, priv_fault, irq_req, e.data, e.wen, e.flt, e.irq);
         end
      end
   end

   // driver: one operation per cycle, called at posedge+1
   task automatic step(input logic r, input logic w, input logic [4:0] idx,
                       input logic [4:0] dst, input logic [31:0] wd, input logic u,
                       input logic e, input logic [31:0] ln, input string tag);
      exp_t x;
      x.cd   = 1'b1;
      x.data = (r && !u) ? m_read(idx, ln) : 32'h0;
      x.wen  = r && !u && (dst != 5'd0);
      x.flt  = (r || w) && u;
      x.irq  = m_st[0] && ((ln & m_en) != 32'h0);
      rd_req = r; wr_req = w; ctl_idx = idx; rd_dst = dst; wr_data = wd;
      usr_mode = u; eret = e; irq_lines = ln;
      eq.push_back(x);
      tq.push_back(tag);
      @(posedge clk);
      #1;
      if (e) m_st = m_est;
      else if (w && !u && idx == 5'd0) m_st = wd;
      if (w && !u) begin
         if (idx == 5'd1) m_est = wd;
         if (idx == 5'd2) m_bst = wd;
         if (idx == 5'd3) m_en = wd;
      end
      rd_req = 0; wr_req = 0; eret = 0; usr_mode = 0;
   endtask

   task automatic rd(input logic [4:0] idx, input logic [31:0] ln, input string tag);
      step(1, 0, idx, 5'd3, 32'h0, 0, 0, ln, tag);
   endtask

   task automatic wr(input logic [4:0] idx, input logic [31:0] d, input logic [31:0] ln,
                     input string tag);
      step(0, 1, idx, 5'd0, d, 0, 0, ln, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      // R1: reset values
      rd(0, 32'h0, "R1 status reset");
      rd(1, 32'h0, "R1 esave reset");
      rd(2, 32'h0, "R1 bsave reset");
      rd(3, 32'h0, "R1 enable reset");
      rd(4, 32'hFFFF_FFFF, "R1 pending with zero enable");
      // R2: write and read back each stored slot
      wr(0, 32'h0000_0002, 32'h0, "R2 write status");
      wr(1, 32'hDEAD_BEE1, 32'h0, "R2 write esave");
      wr(2, 32'h1234_5678, 32'h0, "R2 write bsave");
      wr(3, 32'h0000_F0F0, 32'h0, "R2 write enable");
      rd(0, 32'h0, "R2 read status");
      rd(1, 32'h0, "R2 read esave");
      rd(2, 32'h0, "R2 read bsave");
      rd(3, 32'h0, "R2 read enable");
      // R3: live pending under distinct line patterns
      rd(4, 32'h0000_FFFF, "R3 pending low half");
      rd(4, 32'hFFFF_0F00, "R3 pending disjoint");
      rd(4, 32'hA5A5_A5A5, "R3 pending mixed");
      // R8: request follows status bit 0 and enable with no extra delay
      rd(0, 32'h0000_F0F0, "R8 masked by status bit 0");
      wr(0, 32'h0000_0001, 32'h0000_F0F0, "R8 status write cycle");
      rd(0, 32'h0000_F0F0, "R8 request after status write");
      rd(0, 32'h0000_0F0F, "R8 lines outside enable");
      wr(3, 32'h0, 32'h0000_F0F0, "R8 enable clear cycle");
      rd(3, 32'h0000_F0F0, "R8 request gone after enable clear");
      wr(3, 32'h0000_F0F0, 32'h0, "R8 enable restore");
      // R4: write to pending slot changes nothing
      step(0, 1, 5'd4, 5'd0, 32'hFFFF_FFFF, 0, 0, 32'h0, "R4 pending write");
      rd(3, 32'h0, "R4 enable intact");
      rd(0, 32'h0, "R4 status intact");
      rd(4, 32'hFFFF_FFFF, "R4 pending still masked");
      // R5: user-mode accesses
      step(0, 1, 5'd3, 5'd0, 32'h0000_FFFF, 1, 0, 32'h0, "R5 user write fault");
      rd(3, 32'h0, "R5 enable unchanged");
      step(1, 0, 5'd0, 5'd3, 32'h0, 1, 0, 32'h0, "R5 user read fault");
      // R6: destination register 0
      step(1, 0, 5'd0, 5'd0, 32'h0, 0, 0, 32'h0, "R6 dst zero discarded");
      // R7: exception return
      wr(1, 32'h0000_0004, 32'h0, "R7 set esave");
      step(0, 0, 5'd0, 5'd0, 32'h0, 0, 1, 32'h0, "R7 eret");
      rd(0, 32'h0, "R7 status restored");
      wr(1, 32'h0000_0009, 32'h0, "R7 set esave again");
      step(0, 1, 5'd0, 5'd0, 32'h0000_0077, 0, 1, 32'h0, "R7 eret beats status write");
      rd(0, 32'h0000_F0F0, "R7 status after race");
      // R9: identifier and unused slots
      rd(5, 32'h0, "R9 identifier");
      rd(6, 32'h0, "R9 slot 6 zero");
      rd(31, 32'h0, "R9 slot 31 zero");
      wr(17, 32'hFFFF_FFFF, 32'h0, "R9 write unused slot");
      rd(17, 32'h0, "R9 unused slot still zero");
      wr(5, 32'h0, 32'h0, "R9 write identifier");
      rd(5, 32'h0, "R9 identifier unchanged");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1 actual=hung expected=complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule